// File: doc/BRIEF.md
# Socket Buffer Transfer Sequencer

This block drives one socket of a hardware network controller through a frame-level SPI master. Each frame moves one byte: it has a block select, a 16-bit address, a direction and a data byte. The host pulses a start line to either push `send_len` bytes from a local staging memory into the socket's transmit buffer, or pull whatever the socket has received into that staging memory.

The sequencer works through the fixed access sequence on its own. It reads the pointers it needs, moves the payload byte by byte, writes back the advanced pointer and issues the socket command. It then polls the command register until the controller clears it. When the operation ends, `done` pulses for one cycle together with a result code and a byte count.

Each socket buffer is a 2 KB slice of the controller's shared on-chip memory. Every 16-bit register is read twice, and its value is used only when both readings agree.

Top module: `sbx_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `fr_req` and `stg_we` are low. No frame is requested while `busy` is low.
- R2: A send issues its frames in this order:
  - a status read at block 0, address 0x0003;
  - a double read of the free size at 0x0020/0x0021;
  - a double read of the TX write pointer at 0x0024/0x0025;
  - one write per payload byte at block 1;
  - a write of the new pointer, high byte to 0x0024 and then low byte to 0x0025;
  - a write of 0x20 to the command register at 0x0001;
  - polling reads of 0x0001.
- R3: If the status byte is not 0x17, the send ends at once with result 1 and no further frames.
- R4: If `send_len` exceeds the free size, the send ends with result 1 replaced by result 2, and no buffer or pointer write is made. A length equal to the free size is accepted.
- R5: Payload byte i (staging address i) goes to buffer offset (P+i) AND 0x7FF, where P is the pointer read. The pointer written back is (P+N) mod 65536.
- R6: A receive issues its frames in this order:
  - a double read of the received size at 0x0026/0x0027;
  - a double read of the RX read pointer at 0x0028/0x0029;
  - N reads at block 2, offset (P+i) AND 0x7FF, with byte i stored at staging address i;
  - a pointer write of (P+N) mod 65536 to 0x0028/0x0029;
  - a write of 0x40 to 0x0001;
  - polling reads.
  N is the received size, limited to 2048.
- R7: A receive that finds a received size of 0 ends with result 0 and count 0, and issues no further frames.
- R8: A 16-bit register is read as high byte, low byte, high byte, low byte. If the two values differ, all four reads are repeated. After 4 consecutive mismatches the operation ends with result 4.
- R9: After the command write, the command register is read repeatedly. A reading of zero ends the operation with result 0. If 16 consecutive readings are nonzero, the operation ends with result 3.
- R10: While `fr_req` is high and `fr_ack` is low, the frame's block, address, direction and write data do not change. Each acknowledge completes exactly one frame.
- R11: A start pulse that arrives while `busy` is high has no effect. If both starts are high together while idle, the send is taken.
- R12: `done` is a single-cycle pulse, and `busy` is low in that cycle. `err_code` and `xfer_count` are valid with `done`, and `xfer_count` is 0 for any nonzero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_send | input | 1 | Start a send (idle only) |
| start_recv | input | 1 | Start a receive (idle only) |
| send_len | input | 12 | Byte count for a send |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result: 0 ok, 1 not established, 2 no room, 3 command timeout, 4 unstable register |
| xfer_count | output | 12 | Bytes moved by the finished operation |
| fr_req | output | 1 | Frame request, held until acknowledged |
| fr_write | output | 1 | Frame direction, 1 = write |
| fr_blk | output | 2 | Block select: 0 socket registers, 1 TX buffer, 2 RX buffer |
| fr_addr | output | 16 | Register address or buffer offset |
| fr_wdata | output | 8 | Write byte |
| fr_ack | input | 1 | Frame done; read byte valid |
| fr_rdata | input | 8 | Read byte |
| stg_addr | output | 11 | Staging memory address |
| stg_we | output | 1 | Staging memory write strobe |
| stg_wdata | output | 8 | Staging memory write byte |
| stg_rdata | input | 8 | Staging memory read byte (combinational) |

## Verification
The retry path of the double read is the hardest situation to reach from the ports. A real controller only shows two different readings when its value changes between them, so the bench's controller model flips the last byte of a chosen number of four-read groups. This exercises three cases: recovery after some mismatches, the exact limit of four, and a mismatch on the receive size register. The command-timeout boundary is reached by holding the command register nonzero for exactly 15 polls, which must succeed, and for more than 16 polls, which must fail. A pointer near 0xFFFE forces the buffer offset and the written-back pointer to wrap within a single transfer.

// File: rtl/sbx_pkg.sv
// Shared encodings for the socket buffer transfer sequencer.
// Assumes one socket whose registers sit in block 0 of the frame interface.
package sbx_pkg;
    localparam logic [1:0]  BLK_SOCK   = 2'd0;
    localparam logic [1:0]  BLK_TX     = 2'd1;
    localparam logic [1:0]  BLK_RX     = 2'd2;
    localparam logic [15:0] REG_CMD    = 16'h0001;
    localparam logic [15:0] REG_STAT   = 16'h0003;
    localparam logic [15:0] REG_TXFREE = 16'h0020;
    localparam logic [15:0] REG_TXWR   = 16'h0024;
    localparam logic [15:0] REG_RXSIZE = 16'h0026;
    localparam logic [15:0] REG_RXRD   = 16'h0028;
    localparam logic [7:0]  CMD_SEND   = 8'h20;
    localparam logic [7:0]  CMD_RECV   = 8'h40;
    localparam logic [7:0]  STAT_EST   = 8'h17;

    typedef enum logic [3:0] {
        S_IDLE, S_STAT, S_PAIR, S_EVAL, S_XFER, S_PTRH, S_PTRL, S_CMD, S_POLL
    } sbx_state_t;

    typedef enum logic [1:0] {P_FREE, P_TXWR, P_RXSIZE, P_RXRD} sbx_pair_t;

    typedef enum logic [2:0] {
        E_NONE = 3'd0, E_NOTEST = 3'd1, E_NOROOM = 3'd2,
        E_TIMEOUT = 3'd3, E_UNSTABLE = 3'd4
    } sbx_err_t;
endpackage

// File: rtl/sbx_dual_read.sv
// Collects two back-to-back readings of a 16-bit register, high byte first.
// Assumes byte index 0..3 = first high, first low, second high, second low.
module sbx_dual_read (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap,
    input  logic [1:0]  idx,
    input  logic [7:0]  din,
    output logic [15:0] val,
    output logic        match
);
    logic [15:0] first_q, second_q;

    // Store each arriving byte into its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= '0;
            second_q <= '0;
        end else if (cap) begin
            case (idx)
                2'd0: first_q[15:8]  <= din;
                2'd1: first_q[7:0]   <= din;
                2'd2: second_q[15:8] <= din;
                default: second_q[7:0] <= din;
            endcase
        end
    end

    assign val   = second_q;
    assign match = (first_q == second_q);
endmodule

// File: rtl/sbx_limit_ctr.sv
// Saturating attempt counter; 'last' flags that the next event is the LIMIT-th.
// Assumes clr has priority over inc.
module sbx_limit_ctr #(
    parameter  int LIMIT = 4,
    localparam int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    logic [CW-1:0] cnt;

    // Count events, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc && cnt != CW'(LIMIT))
            cnt <= cnt + CW'(1);
    end

    assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/sbx_buf_addr.sv
// Maps a 16-bit socket pointer plus byte index to an offset inside the socket buffer.
// Assumes BUF_BYTES is a power of two.
module sbx_buf_addr #(
    parameter  int BUF_BYTES = 2048,
    localparam int LEN_W     = $clog2(BUF_BYTES) + 1
) (
    input  logic [15:0]      ptr,
    input  logic [LEN_W-1:0] idx,
    output logic [15:0]      off
);
    assign off = (ptr + 16'(idx)) & 16'(BUF_BYTES - 1);
endmodule

// File: rtl/sbx_sequencer.sv
// Socket buffer transfer sequencer: runs send/receive access sequences for one
// socket through a one-byte-per-frame SPI master. Assumes the frame master
// holds fr_ack high for one cycle with fr_rdata valid, and the staging memory
// reads combinationally.
module sbx_sequencer
    import sbx_pkg::*;
#(
    parameter  int BUF_BYTES   = 2048,
    parameter  int POLL_LIMIT  = 16,
    parameter  int RETRY_LIMIT = 4,
    localparam int STG_AW      = $clog2(BUF_BYTES),
    localparam int LEN_W       = STG_AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_send,
    input  logic              start_recv,
    input  logic [LEN_W-1:0]  send_len,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err_code,
    output logic [LEN_W-1:0]  xfer_count,
    output logic              fr_req,
    output logic              fr_write,
    output logic [1:0]        fr_blk,
    output logic [15:0]       fr_addr,
    output logic [7:0]        fr_wdata,
    input  logic              fr_ack,
    input  logic [7:0]        fr_rdata,
    output logic [STG_AW-1:0] stg_addr,
    output logic              stg_we,
    output logic [7:0]        stg_wdata,
    input  logic [7:0]        stg_rdata
);
    sbx_state_t       state;
    sbx_pair_t        pair_sel;
    sbx_err_t         err_q;
    logic             op_recv;
    logic [1:0]       pidx;
    logic [LEN_W-1:0] cnt, idx, count_q;
    logic [15:0]      ptr, pair_val, pair_base, buf_off, nptr, ptr_reg;
    logic             pair_match, retry_last, poll_last, done_q;

    sbx_dual_read u_dual (
        .clk(clk), .rst_n(rst_n), .cap(state == S_PAIR && fr_ack),
        .idx(pidx), .din(fr_rdata), .val(pair_val), .match(pair_match)
    );

    sbx_limit_ctr #(.LIMIT(RETRY_LIMIT)) u_retry (
        .clk(clk), .rst_n(rst_n),
        .clr(state == S_IDLE || (state == S_EVAL && pair_match)),
        .inc(state == S_EVAL && !pair_match), .last(retry_last)
    );

    sbx_limit_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst_n(rst_n), .clr(state == S_CMD),
        .inc(state == S_POLL && fr_ack && fr_rdata != 8'h00), .last(poll_last)
    );

    sbx_buf_addr #(.BUF_BYTES(BUF_BYTES)) u_addr (
        .ptr(ptr), .idx(idx), .off(buf_off)
    );

    assign nptr    = ptr + 16'(cnt);
    assign ptr_reg = op_recv ? REG_RXRD : REG_TXWR;

    // Address of the 16-bit register currently being double-read.
    always_comb begin
        case (pair_sel)
            P_FREE:   pair_base = REG_TXFREE;
            P_TXWR:   pair_base = REG_TXWR;
            P_RXSIZE: pair_base = REG_RXSIZE;
            default:  pair_base = REG_RXRD;
        endcase
    end

    // Frame fields decoded from the current step.
    always_comb begin
        fr_req   = 1'b0;
        fr_write = 1'b0;
        fr_blk   = BLK_SOCK;
        fr_addr  = 16'h0000;
        fr_wdata = 8'h00;
        case (state)
            S_STAT: begin
                fr_req  = 1'b1;
                fr_addr = REG_STAT;
            end
            S_PAIR: begin
                fr_req  = 1'b1;
                fr_addr = pair_base + 16'(pidx[0]);
            end
            S_XFER: begin
                fr_req   = 1'b1;
                fr_blk   = op_recv ? BLK_RX : BLK_TX;
                fr_addr  = buf_off;
                fr_write = !op_recv;
                fr_wdata = op_recv ? 8'h00 : stg_rdata;
            end
            S_PTRH: begin
                fr_req   = 1'b1;
                fr_write = 1'b1;
                fr_addr  = ptr_reg;
                fr_wdata = nptr[15:8];
            end
            S_PTRL: begin
                fr_req   = 1'b1;
                fr_write = 1'b1;
                fr_addr  = ptr_reg + 16'd1;
                fr_wdata = nptr[7:0];
            end
            S_CMD: begin
                fr_req   = 1'b1;
                fr_write = 1'b1;
                fr_addr  = REG_CMD;
                fr_wdata = op_recv ? CMD_RECV : CMD_SEND;
            end
            S_POLL: begin
                fr_req  = 1'b1;
                fr_addr = REG_CMD;
            end
            default: ;
        endcase
    end

    // Step through the access sequence and record the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            pair_sel <= P_FREE;
            err_q    <= E_NONE;
            op_recv  <= 1'b0;
            pidx     <= 2'd0;
            cnt      <= '0;
            idx      <= '0;
            count_q  <= '0;
            ptr      <= 16'h0000;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start_send) begin
                        op_recv <= 1'b0;
                        cnt     <= send_len;
                        err_q   <= E_NONE;
                        count_q <= '0;
                        state   <= S_STAT;
                    end else if (start_recv) begin
                        op_recv  <= 1'b1;
                        pair_sel <= P_RXSIZE;
                        pidx     <= 2'd0;
                        err_q    <= E_NONE;
                        count_q  <= '0;
                        state    <= S_PAIR;
                    end
                end
                S_STAT: if (fr_ack) begin
                    if (fr_rdata == STAT_EST) begin
                        pair_sel <= P_FREE;
                        pidx     <= 2'd0;
                        state    <= S_PAIR;
                    end else begin
                        err_q  <= E_NOTEST;
                        done_q <= 1'b1;
                        state  <= S_IDLE;
                    end
                end
                S_PAIR: if (fr_ack) begin
                    pidx <= pidx + 2'd1;
                    if (pidx == 2'd3) state <= S_EVAL;
                end
                S_EVAL: begin
                    pidx <= 2'd0;
                    if (!pair_match) begin
                        if (retry_last) begin
                            err_q  <= E_UNSTABLE;
                            done_q <= 1'b1;
                            state  <= S_IDLE;
                        end else begin
                            state <= S_PAIR;
                        end
                    end else begin
                        case (pair_sel)
                            P_FREE: begin
                                if (16'(cnt) > pair_val) begin
                                    err_q  <= E_NOROOM;
                                    done_q <= 1'b1;
                                    state  <= S_IDLE;
                                end else begin
                                    pair_sel <= P_TXWR;
                                    state    <= S_PAIR;
                                end
                            end
                            P_TXWR: begin
                                ptr   <= pair_val;
                                idx   <= '0;
                                state <= (cnt == '0) ? S_PTRH : S_XFER;
                            end
                            P_RXSIZE: begin
                                if (pair_val == 16'h0000) begin
                                    done_q <= 1'b1;
                                    state  <= S_IDLE;
                                end else begin
                                    cnt <= (pair_val > 16'(BUF_BYTES)) ?
                                           LEN_W'(BUF_BYTES) : pair_val[LEN_W-1:0];
                                    pair_sel <= P_RXRD;
                                    state    <= S_PAIR;
                                end
                            end
                            default: begin
                                ptr   <= pair_val;
                                idx   <= '0;
                                state <= S_XFER;
                            end
                        endcase
                    end
                end
                S_XFER: if (fr_ack) begin
                    idx <= idx + LEN_W'(1);
                    if (idx == cnt - LEN_W'(1)) state <= S_PTRH;
                end
                S_PTRH: if (fr_ack) state <= S_PTRL;
                S_PTRL: if (fr_ack) state <= S_CMD;
                S_CMD:  if (fr_ack) state <= S_POLL;
                S_POLL: if (fr_ack) begin
                    if (fr_rdata == 8'h00) begin
                        count_q <= cnt;
                        done_q  <= 1'b1;
                        state   <= S_IDLE;
                    end else if (poll_last) begin
                        err_q  <= E_TIMEOUT;
                        done_q <= 1'b1;
                        state  <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy       = (state != S_IDLE);
    assign done       = done_q;
    assign err_code   = err_q;
    assign xfer_count = count_q;
    assign stg_addr   = idx[STG_AW-1:0];
    assign stg_we     = (state == S_XFER) && op_recv && fr_ack;
    assign stg_wdata  = fr_rdata;
endmodule

// File: rtl/sbx_sequencer_chk.sv
// Port-level protocol checks for sbx_sequencer, attached by bind.
// Assumes the synchronous active-low reset of the checked block.
module sbx_sequencer_chk #(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic [2:0]       err_code,
    input logic [LEN_W-1:0] xfer_count,
    input logic             fr_req,
    input logic             fr_write,
    input logic [1:0]       fr_blk,
    input logic [15:0]      fr_addr,
    input logic [7:0]       fr_wdata,
    input logic             fr_ack,
    input logic             stg_we
);
    // R10: an unacknowledged frame keeps every field
    assert_frame_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fr_req && !fr_ack |=> fr_req && $stable(fr_blk) && $stable(fr_addr)
                              && $stable(fr_write) && $stable(fr_wdata));

    // R6: the receive buffer is only read
    assert_rx_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fr_req && fr_blk == 2'd2 |-> !fr_write);

    // R2: the transmit buffer is only written
    assert_tx_write_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fr_req && fr_blk == 2'd1 |-> fr_write);

    // R6: staging writes only land with an acknowledged receive-buffer read
    assert_stage_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stg_we |-> fr_ack && fr_req && fr_blk == 2'd2);

    // R12: completion is a single-cycle pulse
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: busy is low while done is shown
    assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R12: a failed operation reports no bytes
    assert_err_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_code != 3'd0 |-> xfer_count == '0);

    // R1: nothing leaves the block while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fr_req && !stg_we);
endmodule

bind sbx_sequencer sbx_sequencer_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/sbx_sequencer_tb.sv
`timescale 1ns/1ps
// Bench: behavioural controller model plus an expected-frame queue built from the requirements.
module sbx_sequencer_tb;
    localparam time TCK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_send = 1'b0, start_recv = 1'b0;
    logic [11:0] send_len = '0;
    logic        busy, done, fr_req, fr_write, stg_we;
    logic [2:0]  err_code;
    logic [11:0] xfer_count;
    logic [1:0]  fr_blk;
    logic [15:0] fr_addr;
    logic [7:0]  fr_wdata, stg_wdata, stg_rdata;
    logic        fr_ack = 1'b0;
    logic [7:0]  fr_rdata = 8'h00;
    logic [10:0] stg_addr;

    always #(TCK/2) clk = ~clk;

    sbx_sequencer u_dut (.*);

    typedef struct {
        logic [1:0]  blk;
        logic [15:0] addr;
        logic        w;
        logic [7:0]  d;
    } frm_t;
    frm_t exq[$];

    logic [7:0]  tx_mem [0:2047];
    logic [7:0]  rx_mem [0:2047];
    logic [7:0]  stg    [0:2047];
    logic [7:0]  m_stat, cmd_val;
    logic [15:0] m_free, m_txwr, m_rxsize, m_rxrd;
    int busy_polls, poll_left, glitch_left, pair_rd;
    int n_cmp = 0, n_bad = 0, exp_err, exp_cnt, wait_cnt = 0;
    string cur_req = "R1";
    bit finished = 0;
    logic [1:0]  l_blk;
    logic [15:0] l_addr;
    logic        l_w;
    logic [7:0]  l_d;

    assign stg_rdata = stg[stg_addr];
    always @(posedge clk) if (stg_we) stg[stg_addr] = stg_wdata;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Controller model: answers each frame after three cycles and checks it against the queue.
    always @(negedge clk) begin
        if (fr_ack) begin
            fr_ack = 1'b0;
            wait_cnt = 0;
        end else if (fr_req) begin
            if (wait_cnt == 0) begin
                l_blk = fr_blk; l_addr = fr_addr; l_w = fr_write; l_d = fr_wdata;
            end else if (fr_blk != l_blk || fr_addr != l_addr || fr_write != l_w
                         || (l_w && fr_wdata != l_d)) begin
                chk(0, "R10", "frame changed before ack", {fr_blk, fr_addr}, {l_blk, l_addr});
            end
            if (wait_cnt == 2) begin
                service();
                fr_ack = 1'b1;
            end else wait_cnt++;
        end
    end

    task automatic service();
        frm_t e;
        logic [7:0] rd;
        rd = 8'h00;
        if (exq.size() == 0) begin
            chk(0, cur_req, "unexpected frame", {fr_blk, fr_write, fr_addr}, 0);
        end else begin
            e = exq.pop_front();
            chk(fr_blk == e.blk && fr_addr == e.addr && fr_write == e.w && (!e.w || fr_wdata == e.d),
                cur_req, "frame blk/w/addr/data",
                {fr_blk, fr_write, fr_addr, fr_wdata}, {e.blk, e.w, e.addr, e.d});
        end
        if (fr_write) begin
            if (fr_blk == 2'd1) tx_mem[fr_addr[10:0]] = fr_wdata;
            else case (fr_addr)
                16'h0024: m_txwr[15:8] = fr_wdata;
                16'h0025: m_txwr[7:0]  = fr_wdata;
                16'h0028: m_rxrd[15:8] = fr_wdata;
                16'h0029: m_rxrd[7:0]  = fr_wdata;
                16'h0001: begin cmd_val = fr_wdata; poll_left = busy_polls; end
                default: ;
            endcase
        end else if (fr_blk == 2'd2) begin
            rd = rx_mem[fr_addr[10:0]];
        end else begin
            case (fr_addr)
                16'h0003: rd = m_stat;
                16'h0001: if (poll_left > 0) begin rd = cmd_val; poll_left--; end
                16'h0020: rd = m_free[15:8];
                16'h0021: rd = m_free[7:0];
                16'h0024: rd = m_txwr[15:8];
                16'h0025: rd = m_txwr[7:0];
                16'h0026: rd = m_rxsize[15:8];
                16'h0027: rd = m_rxsize[7:0];
                16'h0028: rd = m_rxrd[15:8];
                16'h0029: rd = m_rxrd[7:0];
                default: ;
            endcase
            if (fr_addr >= 16'h0020 && fr_addr <= 16'h0029) begin
                pair_rd++;
                if (pair_rd % 4 == 0 && glitch_left > 0) begin
                    rd = rd ^ 8'h01;
                    glitch_left--;
                end
            end
        end
        fr_rdata = rd;
    endtask

    task automatic exp_f(input logic [1:0] b, input logic [15:0] a, input logic w, input logic [7:0] d);
        frm_t f;
        f.blk = b; f.addr = a; f.w = w; f.d = d;
        exq.push_back(f);
    endtask

    task automatic exp_pair(input logic [15:0] a, input int reps);
        for (int r = 0; r < reps; r++) begin
            exp_f(0, a, 0, 0); exp_f(0, a + 1, 0, 0);
            exp_f(0, a, 0, 0); exp_f(0, a + 1, 0, 0);
        end
    endtask

    // Tail shared by both directions: pointer write, command, polls.
    task automatic exp_tail(input logic [15:0] preg, input logic [15:0] np, input logic [7:0] cmd, input int n);
        int polls;
        exp_f(0, preg, 1, np[15:8]);
        exp_f(0, preg + 1, 1, np[7:0]);
        exp_f(0, 16'h0001, 1, cmd);
        polls = (busy_polls + 1 > 16) ? 16 : busy_polls + 1;
        for (int p = 0; p < polls; p++) exp_f(0, 16'h0001, 0, 0);
        exp_err = (busy_polls >= 16) ? 3 : 0;
        exp_cnt = (busy_polls >= 16) ? 0 : n;
    endtask

    task automatic plan_send(input int len);
        exp_cnt = 0;
        exp_f(0, 16'h0003, 0, 0);
        if (m_stat != 8'h17) begin exp_err = 1; return; end
        if (glitch_left >= 4) begin exp_pair(16'h0020, 4); exp_err = 4; return; end
        exp_pair(16'h0020, glitch_left + 1);
        if (len > m_free) begin exp_err = 2; return; end
        exp_pair(16'h0024, 1);
        for (int i = 0; i < len; i++) exp_f(1, (m_txwr + 16'(i)) & 16'h07FF, 1, stg[i]);
        exp_tail(16'h0024, m_txwr + 16'(len), 8'h20, len);
    endtask

    task automatic plan_recv(output int n);
        exp_cnt = 0;
        n = 0;
        if (glitch_left >= 4) begin exp_pair(16'h0026, 4); exp_err = 4; return; end
        exp_pair(16'h0026, glitch_left + 1);
        if (m_rxsize == 0) begin exp_err = 0; return; end
        n = (m_rxsize > 2048) ? 2048 : int'(m_rxsize);
        exp_pair(16'h0028, 1);
        for (int i = 0; i < n; i++) exp_f(2, (m_rxrd + 16'(i)) & 16'h07FF, 0, 0);
        exp_tail(16'h0028, m_rxrd + 16'(n), 8'h40, n);
    endtask

    // Runs one operation; mode 0 send, 1 receive, 2 both starts; poke pulses start_recv mid-run.
    task automatic run(input int mode, input int len, input string req, input bit poke);
        int n, cyc;
        logic [15:0] p0;
        bit seen;
        cur_req = req;
        pair_rd = 0;
        p0 = m_rxrd;
        exq.delete();
        if (mode == 1) plan_recv(n); else plan_send(len);
        @(negedge clk);
        start_send = (mode != 1);
        start_recv = (mode != 0);
        send_len = 12'(len);
        @(negedge clk);
        start_send = 0; start_recv = 0;
        seen = 0;
        for (cyc = 0; cyc < 20000 && !seen; cyc++) begin
            if (poke && cyc == 5) begin start_recv = 1; start_send = 1; end
            if (poke && cyc == 6) begin start_recv = 0; start_send = 0; end
            if (done) seen = 1; else @(negedge clk);
        end
        if (!seen) begin
            chk(0, req, "no done (watchdog)", 0, 1);
            return;
        end
        chk(busy == 0, "R12", "busy at done", busy, 0);
        chk(err_code == 3'(exp_err), req, "err_code", err_code, exp_err);
        chk(xfer_count == 12'(exp_cnt), req, "xfer_count", xfer_count, exp_cnt);
        chk(exq.size() == 0, req, "frames left unissued", exq.size(), 0);
        @(negedge clk);
        chk(done == 0, "R12", "done longer than one cycle", done, 0);
        if (mode == 1 && exp_err == 0)
            for (int i = 0; i < exp_cnt; i++)
                chk(stg[i] == rx_mem[(p0 + 16'(i)) & 16'h07FF], "R6", "staged byte",
                    stg[i], rx_mem[(p0 + 16'(i)) & 16'h07FF]);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(TCK * 150000);
        chk(0, "R12", "global watchdog expired", 0, 1);
        summary();
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin
            stg[i] = 8'(i * 7 + 3);
            rx_mem[i] = 8'(i ^ 8'h5A);
            tx_mem[i] = 8'h00;
        end
        m_stat = 8'h17; m_free = 16'd2048; m_txwr = 16'h1234;
        m_rxsize = 16'd0; m_rxrd = 16'd0; cmd_val = 8'h00;
        busy_polls = 2; poll_left = 0; glitch_left = 0; pair_rd = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: quiet after reset
        chk(!busy && !done && !fr_req && !stg_we, "R1", "reset outputs",
            {busy, done, fr_req, stg_we}, 0);

        run(0, 5, "R2", 0);                                  // R2: basic send
        m_txwr = 16'hFFFE; run(0, 4, "R5", 0);               // R5: offset and pointer wrap
        chk(m_txwr == 16'h0002, "R5", "written tx pointer", m_txwr, 16'h0002);
        m_stat = 8'h13; run(0, 3, "R3", 0); m_stat = 8'h17;  // R3: not established
        m_free = 16'd9; run(0, 10, "R4", 0);                 // R4: too long
        m_free = 16'd8; m_txwr = 16'h0100; run(0, 8, "R4", 0); // R4: exactly fits
        m_free = 16'd2048;
        m_rxsize = 16'd6; m_rxrd = 16'h07FC; run(1, 0, "R6", 0); // R6: receive across wrap
        chk(m_rxrd == 16'h0802, "R6", "written rx pointer", m_rxrd, 16'h0802);
        m_rxsize = 16'd0; run(1, 0, "R7", 0);                // R7: nothing pending
        glitch_left = 3; run(0, 2, "R8", 0);                 // R8: recovers after 3 mismatches
        glitch_left = 4; run(0, 2, "R8", 0);                 // R8: fails on the 4th
        m_rxsize = 16'd3; glitch_left = 1; run(1, 0, "R8", 0); // R8: receive size retried
        glitch_left = 0;
        busy_polls = 15; run(0, 1, "R9", 0);                 // R9: 16th poll reads zero
        busy_polls = 40; run(0, 1, "R9", 0);                 // R9: timeout
        busy_polls = 2;
        run(0, 3, "R11", 1);                                 // R11: starts while busy ignored
        run(2, 2, "R11", 0);                                 // R11: both starts, send wins
        m_rxsize = 16'd4; m_rxrd = 16'h0010; run(1, 0, "R6", 1); // R11 during receive
        repeat (3) @(negedge clk);
        chk(!busy && !fr_req, "R11", "idle after run", {busy, fr_req}, 0);
        summary();
    end
endmodule